// File: doc/BRIEF.md
# Source-Routed Switch Forwarding Stage

This block is one forwarding stage of a small fabric switch. Routes are chosen by the source. A packet arrives as one wide beat on a valid/ready ingress stream, tagged with the number of the port it came in on. The header carries a hop list and a hop pointer. The stage reads the hop at the pointer and uses it to pick the egress port. It then writes the ingress port number over that hop slot and advances the pointer. After the last switch, the hop slots that were used, read backwards, give the path home. There is no routing table.

The stage handles several cases in hardware, with no software:
- **Failed forward:** if a packet cannot be forwarded (bad pointer, a port that does not exist, a dead link, or an empty multicast set), the stage builds a failure notice. The notice carries the reversed path and goes straight back out of the ingress port.
- **Source filter:** the header names the originating node, and a per-source allow vector either admits or discards the packet.
- **Multicast:** a multicast packet is copied to the ports in its port mask. It is released only after every selected port has taken it.
- **Bad CRC:** every packet carries a CRC that is checked on arrival. A packet that fails the check is replaced by an error report addressed to a fixed management port.

The stage holds at most one packet. Backpressure never loses a packet; packets are discarded only for the reasons listed in the requirements.

Top module: `sr_path_switch`

## Requirements

**Packet format.** The packet is 71 bits. Fields, from MSB to LSB:

| Field | Bits | Meaning |
|---|---|---|
| kind | [70:69] | 0 data, 1 failure notice, 2 CRC report |
| mcast | [68] | multicast flag |
| ptr | [67:64] | hop pointer |
| hcnt | [63:60] | number of valid hops |
| hops | [59:36] | eight 3-bit hops; hop j at [38+3j:36+3j] |
| pmask | [35:28] | multicast port mask |
| src | [27:24] | originating node |
| payload | [23:8] | payload |
| crc | [7:0] | CRC |

- R1: A data packet that is CRC-clean, from an allowed source, with mcast=0, hcnt≤8, ptr<hcnt, hop h=hops[ptr] < NUM_PORTS and link h up, is forwarded on port h only. Hop slot ptr is replaced by the ingress port, ptr is incremented, all other fields are kept, and the CRC is regenerated.
- R2: A failure notice has:
  - kind=1, mcast=0, ptr=0, pmask=0 and src=SWITCH_ID.
  - hcnt=L, where L=min(ptr, hcnt, 8).
  - hops[j]=incoming hops[L-1-j] for j<L, and 0 for j≥L.
  - payload = {reason[3:0], 1'b0, ingress port[2:0], incoming src[3:0], 4'h0}.
  
  It is sent on the ingress port with a valid CRC.
- R3: A unicast packet whose hop names a port with its link down causes a notice with reason 1. A notice is sent only if the ingress port's own link is up; otherwise nothing is emitted.
- R4: hcnt>8 or ptr≥hcnt gives a notice with reason 2. A hop value ≥ NUM_PORTS gives a notice with reason 3.
- R5: A CRC-clean packet whose src bit in the allow vector is 0 is discarded with no output.
- R6: A multicast packet (mcast=1) goes to the set pmask ∧ links up ∧ existing ports ∧ ¬ingress port, with its header unchanged. If that set is empty, a notice with reason 4 is sent instead.
- R7: Outputs hold their valid signals and data until each selected port takes the packet. Ingress ready stays low until the last selected port has accepted. No packet is lost to backpressure.
- R8: The CRC is CRC-8, polynomial 0x07, initial value 0, computed MSB first over bits [70:8].
  - On a mismatch, a report goes only to MGMT_PORT: kind=2, src=SWITCH_ID, payload = {5'b0, ingress port, received crc}, all other fields 0.
  - The report is sent only if the MGMT_PORT link is up.
  - The CRC check takes precedence over the source filter and over routing.
- R9: A packet whose kind is not data is routed like data. If its routing fails, it is discarded without a notice.
- R10: During and right after reset, ingress ready is 1 and no output valid is set.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | NUM_PORTS | Per-port link usable |
| src_allow_i | input | 16 | Per-source admit bit |
| in_valid_i | input | 1 | Ingress packet valid |
| in_ready_o | output | 1 | Stage can take a packet |
| in_port_i | input | 3 | Port the packet arrived on |
| in_pkt_i | input | 71 | Ingress packet |
| out_valid_o | output | NUM_PORTS | Per-port egress valid |
| out_ready_i | input | NUM_PORTS | Per-port egress ready |
| out_pkt_o | output | 71 | Egress packet, shared by all ports |

## Verification

Several of the block's decisions can apply to the same packet in one cycle, so precedence has to be checked.

- **CRC versus source filter:** one vector has a corrupted CRC and a denied source. The bench expects only the management report.
- **CRC versus dead management link:** another vector has a corrupted CRC while the management link is down. The bench expects silence.
- **Multicast release versus new ingress:** a second packet is held on the ingress while a multicast is only partly accepted. The bench judges that the second packet is taken only after the last port accepts, and that it then comes out intact.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int PORT_W   = 3;
  localparam int MAX_HOPS = 8;
  localparam int HIDX_W   = $clog2(MAX_HOPS);
  localparam int PTR_W    = 4;
  localparam int SRC_W    = 4;
  localparam int NUM_SRC  = 2 ** SRC_W;
  localparam int MASK_W   = 8;
  localparam int PAY_W    = 16;
  localparam int CRC_W    = 8;
  localparam int REASON_W = 4;

  typedef logic [PORT_W-1:0] port_t;

  typedef enum logic [1:0] {
    K_DATA   = 2'd0,
    K_NOTICE = 2'd1,
    K_CRCREP = 2'd2,
    K_RSVD   = 2'd3
  } kind_e;

  typedef enum logic [REASON_W-1:0] {
    RS_NONE      = 4'd0,
    RS_LINK_DOWN = 4'd1,
    RS_BAD_PTR   = 4'd2,
    RS_BAD_PORT  = 4'd3,
    RS_MC_EMPTY  = 4'd4
  } reason_e;

  typedef struct packed {
    kind_e                     kind;
    logic                      mcast;
    logic [PTR_W-1:0]          ptr;
    logic [PTR_W-1:0]          hcnt;
    port_t [MAX_HOPS-1:0]      hops;
    logic [MASK_W-1:0]         pmask;
    logic [SRC_W-1:0]          src;
    logic [PAY_W-1:0]          payload;
    logic [CRC_W-1:0]          crc;
  } pkt_t;

  localparam int PKT_W  = $bits(pkt_t);
  localparam int BODY_W = PKT_W - CRC_W;
endpackage

// File: rtl/sr_crc.sv
module sr_crc #(
  parameter int                DATA_W = 63,
  parameter int                CRC_W  = 8,
  parameter logic [CRC_W-1:0]  POLY   = 8'h07
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] acc;
  logic             fb;

  always_comb begin
    acc = '0;
    fb  = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ data_i[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  assign crc_o = acc;
endmodule

// File: rtl/sr_route_decide.sv
module sr_route_decide
  import sr_pkg::*;
#(
  parameter int               NUM_PORTS = 6,
  parameter logic [SRC_W-1:0] SWITCH_ID = 4'hA,
  parameter int               MGMT_PORT = 0
) (
  input  pkt_t                 pkt_i,
  input  port_t                port_i,
  input  logic                 crc_ok_i,
  input  logic [NUM_PORTS-1:0] link_up_i,
  input  logic [NUM_SRC-1:0]   src_allow_i,
  output logic [NUM_PORTS-1:0] mask_o,
  output pkt_t                 pkt_o
);
  localparam logic [MASK_W-1:0]    PORT_EXIST = MASK_W'((1 << NUM_PORTS) - 1);
  localparam logic [NUM_PORTS-1:0] MGMT_OH    = NUM_PORTS'(1) << MGMT_PORT;

  logic [MASK_W-1:0] up_w, in_oh, mc_set;
  logic [HIDX_W-1:0] hidx;
  port_t             hop;
  reason_e           reason;
  logic [PTR_W-1:0]  lim, ret_len;

  assign up_w   = MASK_W'(link_up_i);
  assign in_oh  = MASK_W'(1) << port_i;
  assign mc_set = pkt_i.pmask & up_w & PORT_EXIST & ~in_oh;
  assign hidx   = pkt_i.ptr[HIDX_W-1:0];
  assign hop    = pkt_i.hops[hidx];

  // reason code in precedence order
  always_comb begin
    reason = RS_NONE;
    if (pkt_i.mcast) begin
      if (mc_set == '0) reason = RS_MC_EMPTY;
    end else if (pkt_i.hcnt > PTR_W'(MAX_HOPS) || pkt_i.ptr >= pkt_i.hcnt) begin
      reason = RS_BAD_PTR;
    end else if (int'(hop) >= NUM_PORTS) begin
      reason = RS_BAD_PORT;
    end else if (!up_w[hop]) begin
      reason = RS_LINK_DOWN;
    end
  end

  // hops already consumed upstream, bounded by list size
  always_comb begin
    lim     = (pkt_i.ptr < pkt_i.hcnt) ? pkt_i.ptr : pkt_i.hcnt;
    ret_len = (lim > PTR_W'(MAX_HOPS)) ? PTR_W'(MAX_HOPS) : lim;
  end

  always_comb begin
    pkt_o  = pkt_i;
    mask_o = '0;
    if (!crc_ok_i) begin
      pkt_o         = '0;
      pkt_o.kind    = K_CRCREP;
      pkt_o.src     = SWITCH_ID;
      pkt_o.payload = PAY_W'({port_i, pkt_i.crc});
      mask_o        = link_up_i & MGMT_OH;
    end else if (!src_allow_i[pkt_i.src]) begin
      mask_o = '0;
    end else if (reason == RS_NONE) begin
      if (pkt_i.mcast) begin
        mask_o = mc_set[NUM_PORTS-1:0];
      end else begin
        pkt_o.hops[hidx] = port_i;
        pkt_o.ptr        = pkt_i.ptr + PTR_W'(1);
        mask_o           = NUM_PORTS'(1) << hop;
      end
    end else if (pkt_i.kind == K_DATA && up_w[port_i]) begin
      pkt_o      = '0;
      pkt_o.kind = K_NOTICE;
      pkt_o.src  = SWITCH_ID;
      pkt_o.hcnt = ret_len;
      for (int j = 0; j < MAX_HOPS; j++) begin
        if (j < int'(ret_len))
          pkt_o.hops[j] = pkt_i.hops[HIDX_W'(int'(ret_len) - 1 - j)];
      end
      pkt_o.payload = {reason, 1'b0, port_i, pkt_i.src, 4'h0};
      mask_o        = NUM_PORTS'(1) << port_i;
    end
  end
endmodule

// File: rtl/sr_fanout.sv
module sr_fanout #(
  parameter int NUM_PORTS = 6,
  parameter int PKT_W     = 71
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [NUM_PORTS-1:0] mask_i,
  input  logic [PKT_W-1:0]     pkt_i,
  input  logic [NUM_PORTS-1:0] out_ready_i,
  output logic [NUM_PORTS-1:0] out_valid_o,
  output logic [PKT_W-1:0]     pkt_o,
  output logic                 idle_o
);
  logic [NUM_PORTS-1:0] pend_q, pend_d;
  logic [PKT_W-1:0]     pkt_q;

  always_comb begin
    pend_d = pend_q & ~out_ready_i;
    if (load_i) pend_d = mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      pkt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (load_i) pkt_q <= pkt_i;
    end
  end

  assign out_valid_o = pend_q;
  assign pkt_o       = pkt_q;
  assign idle_o      = (pend_q == '0);

  AST_PEND_SHRINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0) |=> ((pend_q & ~$past(pend_q)) == '0));  // R7
  AST_PKT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0) |=> $stable(pkt_q));  // R7

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_hold
    AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[g] && !out_ready_i[g]) |=> out_valid_o[g]);  // R7
  end
endmodule

// File: rtl/sr_path_switch.sv
module sr_path_switch
  import sr_pkg::*;
#(
  parameter int               NUM_PORTS = 6,
  parameter logic [SRC_W-1:0] SWITCH_ID = 4'hA,
  parameter int               MGMT_PORT = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] link_up_i,
  input  logic [NUM_SRC-1:0]   src_allow_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [PORT_W-1:0]    in_port_i,
  input  logic [PKT_W-1:0]     in_pkt_i,
  output logic [NUM_PORTS-1:0] out_valid_o,
  input  logic [NUM_PORTS-1:0] out_ready_i,
  output logic [PKT_W-1:0]     out_pkt_o
);
  pkt_t                 in_pkt, dec_pkt, ld_pkt;
  logic [CRC_W-1:0]     crc_in, crc_gen, crc_chk;
  logic                 crc_ok, idle, in_fire;
  logic [NUM_PORTS-1:0] dec_mask;
  logic [MASK_W-1:0]    dec_mask_w;

  assign in_pkt     = pkt_t'(in_pkt_i);
  assign in_ready_o = idle;
  assign in_fire    = in_valid_i & idle;
  assign crc_ok     = (crc_in == in_pkt.crc);
  assign dec_mask_w = MASK_W'(dec_mask);

  sr_crc #(.DATA_W(BODY_W), .CRC_W(CRC_W)) u_crc_in (
    .data_i(in_pkt_i[PKT_W-1:CRC_W]), .crc_o(crc_in));

  sr_route_decide #(.NUM_PORTS(NUM_PORTS), .SWITCH_ID(SWITCH_ID), .MGMT_PORT(MGMT_PORT)) u_decide (
    .pkt_i(in_pkt), .port_i(in_port_i), .crc_ok_i(crc_ok), .link_up_i(link_up_i),
    .src_allow_i(src_allow_i), .mask_o(dec_mask), .pkt_o(dec_pkt));

  sr_crc #(.DATA_W(BODY_W), .CRC_W(CRC_W)) u_crc_gen (
    .data_i(dec_pkt[PKT_W-1:CRC_W]), .crc_o(crc_gen));

  always_comb begin
    ld_pkt     = dec_pkt;
    ld_pkt.crc = crc_gen;
  end

  sr_fanout #(.NUM_PORTS(NUM_PORTS), .PKT_W(PKT_W)) u_fanout (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(in_fire), .mask_i(dec_mask),
    .pkt_i(ld_pkt), .out_ready_i(out_ready_i), .out_valid_o(out_valid_o),
    .pkt_o(out_pkt_o), .idle_o(idle));

  sr_crc #(.DATA_W(BODY_W), .CRC_W(CRC_W)) u_crc_chk (
    .data_i(out_pkt_o[PKT_W-1:CRC_W]), .crc_o(crc_chk));

  AST_OUT_CRC_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o != '0) |-> (crc_chk == out_pkt_o[CRC_W-1:0]));  // R1
  AST_UNICAST_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && !in_pkt.mcast) |-> $onehot0(dec_mask));  // R1
  AST_MC_SKIP_INGRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && crc_ok && in_pkt.mcast && dec_pkt.kind != K_NOTICE) |-> !dec_mask_w[in_port_i]);  // R6
  AST_CRC_TO_MGMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && !crc_ok) |-> ((dec_mask & ~(NUM_PORTS'(1) << MGMT_PORT)) == '0));  // R8
endmodule

// File: tb/test_sr_path_switch.sv
module test_sr_path_switch;
  import sr_pkg::*;

  localparam int NP = 6;
  localparam logic [5:0] L = 6'b111011;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0]   link_up = L, out_valid, out_ready = '0;
  logic [15:0]     src_allow = 16'hFFFE;
  logic            in_valid = 1'b0, in_ready;
  logic [2:0]      in_port = '0;
  logic [PKT_W-1:0] in_pkt = '0, out_pkt;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sr_path_switch i_sr_path_switch (
    .clk_i(clk), .rst_ni(rst_n), .link_up_i(link_up), .src_allow_i(src_allow),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_port_i(in_port), .in_pkt_i(in_pkt),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_pkt_o(out_pkt));

  typedef struct packed {
    logic [2:0] port; logic [5:0] link; logic [1:0] kind; logic mc;
    logic [3:0] ptr; logic [3:0] hcnt; logic [23:0] hops; logic [7:0] pmask;
    logic [3:0] src; logic bad; logic [5:0] emask; logic [1:0] ekind; logic [3:0] erea;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd1, L, 2'd0, 1'b0, 4'd0, 4'd3, 24'o00000453, 8'h00, 4'd5, 1'b0, 6'b001000, 2'd0, 4'd0},
    '{3'd4, L, 2'd0, 1'b0, 4'd2, 4'd4, 24'o00005131, 8'h00, 4'd3, 1'b0, 6'b000010, 2'd0, 4'd0},
    '{3'd5, L, 2'd0, 1'b0, 4'd1, 4'd2, 24'o00000024, 8'h00, 4'd6, 1'b0, 6'b100000, 2'd1, 4'd1},
    '{3'd0, L, 2'd0, 1'b0, 4'd3, 4'd3, 24'o00000531, 8'h00, 4'd7, 1'b0, 6'b000001, 2'd1, 4'd2},
    '{3'd3, L, 2'd0, 1'b0, 4'd0, 4'd9, 24'o00000001, 8'h00, 4'd2, 1'b0, 6'b001000, 2'd1, 4'd2},
    '{3'd1, L, 2'd0, 1'b0, 4'd0, 4'd1, 24'o00000007, 8'h00, 4'd9, 1'b0, 6'b000010, 2'd1, 4'd3},
    '{3'd1, L, 2'd0, 1'b0, 4'd0, 4'd1, 24'o00000003, 8'h00, 4'd0, 1'b0, 6'b000000, 2'd0, 4'd0},
    '{3'd1, L, 2'd0, 1'b1, 4'd0, 4'd0, 24'o00000000, 8'hFF, 4'd4, 1'b0, 6'b111001, 2'd0, 4'd0},
    '{3'd1, L, 2'd0, 1'b1, 4'd0, 4'd0, 24'o00000000, 8'h06, 4'd4, 1'b0, 6'b000010, 2'd1, 4'd4},
    '{3'd4, L, 2'd0, 1'b0, 4'd0, 4'd1, 24'o00000003, 8'h00, 4'd0, 1'b1, 6'b000001, 2'd2, 4'd0},
    '{3'd3, L, 2'd1, 1'b0, 4'd0, 4'd1, 24'o00000002, 8'h00, 4'd5, 1'b0, 6'b000000, 2'd0, 4'd0},
    '{3'd3, L, 2'd2, 1'b0, 4'd0, 4'd1, 24'o00000004, 8'h00, 4'd5, 1'b0, 6'b010000, 2'd2, 4'd0},
    '{3'd0, L, 2'd0, 1'b0, 4'd7, 4'd8, 24'o50000000, 8'h00, 4'd1, 1'b0, 6'b100000, 2'd0, 4'd0},
    '{3'd2, L, 2'd0, 1'b0, 4'd0, 4'd1, 24'o00000002, 8'h00, 4'd5, 1'b0, 6'b000000, 2'd0, 4'd0},
    '{3'd4, 6'b111010, 2'd0, 1'b0, 4'd0, 4'd1, 24'o00000003, 8'h00, 4'd5, 1'b1, 6'b000000, 2'd0, 4'd0}
  };
  localparam string TAGS [NV] = '{"R1", "R1", "R3", "R4", "R4", "R4", "R5", "R6", "R6",
                                  "R8", "R9", "R9", "R1", "R3", "R8"};

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bcrc(input logic [62:0] d);
    logic [7:0] c = '0;
    for (int i = 62; i >= 0; i--) begin
      logic fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic pkt_t seal(input pkt_t p);
    pkt_t q = p;
    q.crc = bcrc(q[70:8]);
    return q;
  endfunction

  function automatic pkt_t expect_pkt(input pkt_t p, input logic [2:0] port, input logic [3:0] rea, input logic bad);
    pkt_t e;
    int len;
    if (bad) begin
      e = '0; e.kind = K_CRCREP; e.src = 4'hA; e.payload = {5'b0, port, p.crc};
    end else if (rea != 0) begin
      len = (p.ptr < p.hcnt) ? int'(p.ptr) : int'(p.hcnt);
      if (len > 8) len = 8;
      e = '0; e.kind = K_NOTICE; e.src = 4'hA; e.hcnt = 4'(len);
      for (int j = 0; j < len; j++) e.hops[j] = p.hops[len - 1 - j];
      e.payload = {rea, 1'b0, port, p.src, 4'h0};
    end else begin
      e = p;
      if (!p.mcast) begin
        e.hops[p.ptr[2:0]] = port;
        e.ptr = p.ptr + 4'd1;
      end
    end
    return seal(e);
  endfunction

  task automatic push(input pkt_t p, input logic [2:0] port);
    @(negedge clk);
    in_valid = 1'b1; in_pkt = p; in_port = port;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = '1;
    @(negedge clk);
    out_ready = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pkt_t p, e, hold_pkt;
    // reset state, R10
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready in reset", 72'(in_ready), 72'd1);
    chk(out_valid == '0, "R10 valid in reset", 72'(out_valid), 72'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == '0, "R10 after reset", 72'({in_ready, out_valid}), 72'h40);

    // vector table
    for (int v = 0; v < NV; v++) begin
      p = '0;
      p.kind = kind_e'(VECS[v].kind); p.mcast = VECS[v].mc; p.ptr = VECS[v].ptr;
      p.hcnt = VECS[v].hcnt; p.hops = VECS[v].hops; p.pmask = VECS[v].pmask;
      p.src = VECS[v].src; p.payload = 16'hC3A0 + 16'(v);
      p = seal(p);
      if (VECS[v].bad) p.crc = p.crc ^ 8'h5A;
      link_up = VECS[v].link;
      push(p, VECS[v].port);
      chk(out_valid == VECS[v].emask, TAGS[v], 72'(out_valid), 72'(VECS[v].emask));
      if (VECS[v].emask != '0) begin
        e = expect_pkt(p, VECS[v].port, VECS[v].erea, VECS[v].bad);
        chk(out_pkt[70:69] == VECS[v].ekind, TAGS[v], 72'(out_pkt[70:69]), 72'(VECS[v].ekind));
        chk(out_pkt == e, TAGS[v], 72'(out_pkt), 72'(e));
        drain();
      end else begin
        @(negedge clk);
      end
      chk(out_valid == '0 && in_ready, "R7 idle after vector", 72'({in_ready, out_valid}), 72'h40);
    end

    // R2: three hops, failure at the third, return path from rewritten slots
    link_up = L;
    p = '0; p.hcnt = 4'd3; p.hops = 24'o00000243; p.src = 4'd6; p.payload = 16'h1234;
    p = seal(p);
    push(p, 3'd1);
    chk(out_valid == 6'b001000, "R1 chain hop A", 72'(out_valid), 72'h08);
    p = pkt_t'(out_pkt);
    drain();
    push(p, 3'd0);
    chk(out_valid == 6'b010000, "R1 chain hop B", 72'(out_valid), 72'h10);
    p = pkt_t'(out_pkt);
    drain();
    push(p, 3'd5);
    e = '0; e.kind = K_NOTICE; e.src = 4'hA; e.hcnt = 4'd2; e.hops = 24'o00000010;
    e.payload = {4'd1, 1'b0, 3'd5, 4'd6, 4'h0};
    e = seal(e);
    chk(out_valid == 6'b100000, "R2 notice port", 72'(out_valid), 72'h20);
    chk(out_pkt == e, "R2 reversed path", 72'(out_pkt), 72'(e));
    drain();

    // R7: multicast under backpressure, second packet waits
    p = '0; p.mcast = 1'b1; p.pmask = 8'hFF; p.src = 4'd4; p.payload = 16'hBEEF;
    p = seal(p);
    push(p, 3'd1);
    hold_pkt = pkt_t'(out_pkt);
    chk(out_valid == 6'b111001, "R6 mcast set", 72'(out_valid), 72'h39);
    in_valid = 1'b1; in_port = 3'd4;
    in_pkt = seal('{kind: K_DATA, mcast: 1'b0, ptr: 4'd0, hcnt: 4'd1, hops: 24'o00000003,
                    pmask: 8'h00, src: 4'd3, payload: 16'h0F0F, crc: 8'h00});
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0 && out_valid == 6'b111001, "R7 stall", 72'({in_ready, out_valid}), 72'h39);
    out_ready = 6'b000001;
    @(negedge clk);
    out_ready = '0;
    chk(out_valid == 6'b111000 && !in_ready, "R7 partial", 72'({in_ready, out_valid}), 72'h38);
    chk(out_pkt == hold_pkt, "R7 data held", 72'(out_pkt), 72'(hold_pkt));
    out_ready = 6'b111000;
    @(negedge clk);
    out_ready = '0;
    chk(out_valid == '0 && in_ready, "R7 release", 72'({in_ready, out_valid}), 72'h40);
    e = expect_pkt(pkt_t'(in_pkt), 3'd4, 4'd0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 6'b001000, "R7 queued packet port", 72'(out_valid), 72'h08);
    chk(out_pkt == e, "R7 queued packet data", 72'(out_pkt), 72'(e));
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule